// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block collects interrupt events from a multi-channel DMA engine and turns them into interrupt lines. Each channel raises single-cycle pulses for five event classes: transfer done, block done, source transaction, destination transaction and error. Each pulse sets a sticky raw bit, one per channel per class. A per-class mask decides which raw bits count. Every channel drives its own interrupt line from its transfer and block events. All channels share one error line.

Software reaches the unit through a plain synchronous port with a word address, write data, a write strobe and combinational read data. The mask registers take a write-enable byte alongside the value byte, so one channel's mask can change without a read-modify-write. Raw bits are cleared by writing ones. A summary register shows which event classes have at least one unmasked pending bit.

The word address is split as bank = `reg_addr[4:3]` and class = `reg_addr[2:0]`. The banks are raw = 0, masked status = 1, mask = 2 and clear = 3. The class codes are transfer = 0, block = 1, source = 2, destination = 3 and error = 4. Address 0x1F is the summary register.

Top module: `dma_irq_ctrl`

## Requirements
- R1: An event pulse on channel i of class c sets raw bit i of that class at the next clock edge. Raw bits are read at address 8*0+c, channel i in read bit i.
- R2: The raw registers ignore writes. A write to address c (0..4) leaves the raw bits unchanged.
- R3: A write to mask address 16+c updates only the channels whose enable bit `reg_wdata[8+i]` is 1, each to `reg_wdata[i]`. Other channels keep their mask bit. A mask bit of 1 means unmasked. A read of 16+c returns the mask in bits [7:0].
- R4: After reset all raw bits are 0 and all mask bits are 0 (masked). A mask write of 0xFF00 leaves every channel of that class masked.
- R5: A write to clear address 24+c clears raw bit i of class c where `reg_wdata[i]` is 1. Zero bits have no effect.
- R6: An event pulse and a clear of the same bit in the same cycle leave the raw bit set.
- R7: The masked status at address 8+c reads as raw AND mask for class c.
- R8: Summary address 0x1F returns in bit c the OR of class c's masked status bits.
- R9: `ch_irq[i]` is the OR of channel i's masked transfer and masked block status.
- R10: `err_irq` is the OR of all masked error status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ev_tfr | input | NUM_CH | Transfer-done pulses, one per channel |
| ev_blk | input | NUM_CH | Block-done pulses |
| ev_src | input | NUM_CH | Source-transaction pulses |
| ev_dst | input | NUM_CH | Destination-transaction pulses |
| ev_err | input | NUM_CH | Error pulses |
| ch_irq | output | NUM_CH | Per-channel interrupt lines |
| err_irq | output | 1 | Shared error interrupt line |

## Verification
Every state change in this unit is caused by an event pulse or a register write, and each takes effect at the single clock edge that samples it. The raw, mask, status and summary reads and both interrupt outputs are combinational from that state, so each result is due exactly one edge after its stimulus. The bench drives its inputs just after a rising edge and holds them through exactly one edge. It then reads the registers and outputs a short settle time later, before the following edge. This puts every check in the first cycle where the result is due. The same-cycle event-and-clear case is driven as one combined stimulus so that both land on the same edge.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants and the class encoding for the DMA interrupt unit.
// Assumes at most 8 channels, so the mask enable byte sits at bits [15:8].
package dma_irq_pkg;
    localparam int NUM_CLASS = 5;
    localparam int REG_W     = 16;
    localparam int EN_LSB    = 8;
    localparam int MAX_CH    = 8;

    typedef enum logic [2:0] {
        CLS_TFR = 3'd0,
        CLS_BLK = 3'd1,
        CLS_SRC = 3'd2,
        CLS_DST = 3'd3,
        CLS_ERR = 3'd4
    } irq_class_e;

    localparam logic [1:0] BANK_RAW = 2'd0;
    localparam logic [1:0] BANK_STS = 2'd1;
    localparam logic [1:0] BANK_MSK = 2'd2;
    localparam logic [1:0] BANK_CLR = 2'd3;
    localparam logic [4:0] ADDR_SUM = 5'h1F;
endpackage

// File: rtl/dma_irq_class.sv
// Module: state for one event class. It holds a sticky raw bit per channel,
// set by event pulses and cleared by write-one-to-clear, and a mask bit per
// channel written through a per-channel enable byte.
// Assumes the write strobes are already decoded for this class.
module dma_irq_class
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ev,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    output logic [NCH-1:0]   raw,
    output logic [NCH-1:0]   mask,
    output logic [NCH-1:0]   masked,
    output logic             any
);
    logic [NCH-1:0] clr_bits;
    logic [NCH-1:0] mask_en;
    logic [NCH-1:0] mask_next;

    // Decode the clear bits and the merged mask value for this class
    always_comb begin
        clr_bits  = clr_we ? wdata[NCH-1:0] : '0;
        mask_en   = mask_we ? wdata[EN_LSB +: NCH] : '0;
        mask_next = (mask & ~mask_en) | (wdata[NCH-1:0] & mask_en);
    end

    // Raw bits: clear first, then the event pulse sets, so an event wins
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_bits) | ev;
    end

    // Mask bits: reset to all masked, update only the enabled channels
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= mask_next;
    end

    // Masked status and the class summary bit
    always_comb begin
        masked = raw & mask;
        any    = |masked;
    end

    // R1: a pulse sets its raw bit by the next edge (R6: even with a clear)
    a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((raw & $past(ev)) == $past(ev)));

    // R5: cleared bits without a concurrent event read 0 next cycle
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw & $past(wdata[NCH-1:0] & ~ev)) == '0));

    // R3: channels without an enable keep their mask bit
    a_r3_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (((mask ^ $past(mask)) & ~$past(wdata[EN_LSB +: NCH])) == '0));

    // R5: with no event and no clear the raw bits hold
    a_r5_raw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && ev == '0) |=> $stable(raw));
endmodule

// File: rtl/dma_irq_regif.sv
// Module: register port decode. It turns address and strobe into per-class
// mask and clear strobes and selects read data from the class state.
// Assumes a single-cycle write strobe and combinational reads.
module dma_irq_regif
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                           we,
    input  logic [4:0]                     addr,
    input  logic [NUM_CLASS-1:0][NCH-1:0]  raw,
    input  logic [NUM_CLASS-1:0][NCH-1:0]  mask,
    input  logic [NUM_CLASS-1:0][NCH-1:0]  masked,
    input  logic [NUM_CLASS-1:0]           summary,
    output logic [NUM_CLASS-1:0]           mask_we,
    output logic [NUM_CLASS-1:0]           clr_we,
    output logic [REG_W-1:0]               rdata
);
    logic [1:0] bank;
    logic [2:0] cls;
    logic       cls_ok;

    // Split the address into bank and class fields
    always_comb begin
        bank   = addr[4:3];
        cls    = addr[2:0];
        cls_ok = (cls < 3'(NUM_CLASS));
    end

    // One write strobe pair per class
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_strobe
        always_comb begin
            mask_we[c] = we && (bank == BANK_MSK) && (cls == 3'(c));
            clr_we[c]  = we && (bank == BANK_CLR) && (cls == 3'(c));
        end
    end

    // Read mux; clear registers read 0, address 0x1F reads the summary
    always_comb begin
        rdata = '0;
        if (addr == ADDR_SUM) begin
            rdata[NUM_CLASS-1:0] = summary;
        end else if (cls_ok) begin
            case (bank)
                BANK_RAW: rdata[NCH-1:0] = raw[cls];
                BANK_STS: rdata[NCH-1:0] = masked[cls];
                BANK_MSK: rdata[NCH-1:0] = mask[cls];
                default:  rdata          = '0;
            endcase
        end
    end

    // Strobes are exclusive: at most one class register written per cycle
    always_comb begin
        a_regif_onehot: assert ($onehot0({mask_we, clr_we}));
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
// Module: top of the DMA interrupt status and mask unit. It bundles the
// event inputs, builds one class block per event type, and forms the
// per-channel and shared error interrupt lines from the masked status.
// Assumes NUM_CH <= 8 and single-cycle event pulses.
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              reg_we,
    output logic [15:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ev_tfr,
    input  logic [NUM_CH-1:0] ev_blk,
    input  logic [NUM_CH-1:0] ev_src,
    input  logic [NUM_CH-1:0] ev_dst,
    input  logic [NUM_CH-1:0] ev_err,
    output logic [NUM_CH-1:0] ch_irq,
    output logic              err_irq
);
    logic [NUM_CLASS-1:0][NUM_CH-1:0] ev_all;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] raw;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] mask;
    logic [NUM_CLASS-1:0][NUM_CH-1:0] masked;
    logic [NUM_CLASS-1:0]             summary;
    logic [NUM_CLASS-1:0]             mask_we;
    logic [NUM_CLASS-1:0]             clr_we;

    // Gather the event inputs by class code
    always_comb begin
        ev_all[CLS_TFR] = ev_tfr;
        ev_all[CLS_BLK] = ev_blk;
        ev_all[CLS_SRC] = ev_src;
        ev_all[CLS_DST] = ev_dst;
        ev_all[CLS_ERR] = ev_err;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        dma_irq_class #(.NCH(NUM_CH)) u_class (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ev_all[c]),
            .mask_we (mask_we[c]),
            .clr_we  (clr_we[c]),
            .wdata   (reg_wdata),
            .raw     (raw[c]),
            .mask    (mask[c]),
            .masked  (masked[c]),
            .any     (summary[c])
        );
    end

    dma_irq_regif #(.NCH(NUM_CH)) u_regif (
        .we      (reg_we),
        .addr    (reg_addr),
        .raw     (raw),
        .mask    (mask),
        .masked  (masked),
        .summary (summary),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .rdata   (reg_rdata)
    );

    // Interrupt lines from the masked status
    always_comb begin
        ch_irq  = masked[CLS_TFR] | masked[CLS_BLK];
        err_irq = |masked[CLS_ERR];
    end

    // R2: a write to a raw address with no events leaves raw state unchanged
    a_r2_raw_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[4:3] == BANK_RAW && ev_all == '0) |=> $stable(raw));

    // R10: the error line follows the error class summary
    a_r10_err_line: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == summary[CLS_ERR]);

    // R9: an active channel line needs an unmasked transfer or block raw bit
    a_r9_ch_line: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq & ~((raw[CLS_TFR] & mask[CLS_TFR]) | (raw[CLS_BLK] & mask[CLS_BLK]))) == '0);

    // R4: a mask-all write with zero values leaves that class fully masked
    a_r4_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 5'h10 && reg_wdata == 16'hFF00) |=> (mask[CLS_TFR] == '0));
endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic            reg_we = 1'b0;
    logic [15:0]     reg_rdata;
    logic [NCH-1:0]  ev_tfr = '0, ev_blk = '0, ev_src = '0, ev_dst = '0, ev_err = '0;
    logic [NCH-1:0]  ch_irq;
    logic            err_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_ctrl #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .ev_tfr(ev_tfr), .ev_blk(ev_blk), .ev_src(ev_src), .ev_dst(ev_dst), .ev_err(ev_err),
        .ch_irq(ch_irq), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One edge with the current inputs, then release strobes and pulses
    task automatic tick();
        @(posedge clk); #1;
        reg_we = 1'b0;
        ev_tfr = '0; ev_blk = '0; ev_src = '0; ev_dst = '0; ev_err = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [15:0] exp);
        reg_addr = a; #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic t_reset();
        rd_check("R4 raw tfr", 5'h00, 16'h0000);
        rd_check("R4 mask tfr", 5'h10, 16'h0000);
        rd_check("R4 mask err", 5'h14, 16'h0000);
        rd_check("R8 summary", 5'h1F, 16'h0000);
        check("R9 ch_irq", {8'h0, ch_irq}, 16'h0000);
        check("R10 err_irq", {15'h0, err_irq}, 16'h0000);
    endtask

    task automatic t_mask_write();
        wr(5'h10, 16'h0505);
        rd_check("R3 mask set", 5'h10, 16'h0005);
        wr(5'h10, 16'h0302);
        rd_check("R3 partial enable", 5'h10, 16'h0006);
        wr(5'h10, 16'h00FF);
        rd_check("R3 no enable", 5'h10, 16'h0006);
        wr(5'h10, 16'hFF00);
        rd_check("R4 mask all", 5'h10, 16'h0000);
    endtask

    task automatic t_events();
        ev_tfr = 8'h81; tick();
        rd_check("R1 raw tfr", 5'h00, 16'h0081);
        rd_check("R7 masked zero", 5'h08, 16'h0000);
        rd_check("R8 summary masked", 5'h1F, 16'h0000);
        check("R9 masked ch_irq", {8'h0, ch_irq}, 16'h0000);
        wr(5'h10, 16'h0101);
        rd_check("R7 masked ch0", 5'h08, 16'h0001);
        rd_check("R8 summary tfr", 5'h1F, 16'h0001);
        check("R9 ch_irq tfr", {8'h0, ch_irq}, 16'h0001);
        ev_src = 8'h0F; ev_dst = 8'hF0; tick();
        rd_check("R1 raw src", 5'h02, 16'h000F);
        rd_check("R1 raw dst", 5'h03, 16'h00F0);
    endtask

    task automatic t_raw_readonly();
        wr(5'h00, 16'h0000);
        rd_check("R2 raw ignores write", 5'h00, 16'h0081);
        wr(5'h02, 16'hFFFF);
        rd_check("R2 raw src ignores write", 5'h02, 16'h000F);
    endtask

    task automatic t_clear();
        wr(5'h18, 16'h0080);
        rd_check("R5 clear bit7", 5'h00, 16'h0001);
        wr(5'h18, 16'h0000);
        rd_check("R5 zero no effect", 5'h00, 16'h0001);
        wr(5'h18, 16'h0001);
        check("R9 ch_irq after clear", {8'h0, ch_irq}, 16'h0000);
    endtask

    task automatic t_race();
        ev_blk = 8'h04; tick();
        ev_blk = 8'h04; reg_addr = 5'h19; reg_wdata = 16'h0004; reg_we = 1'b1;
        tick();
        rd_check("R6 event beats clear", 5'h01, 16'h0004);
        wr(5'h11, 16'h0404);
        check("R9 ch_irq blk", {8'h0, ch_irq}, 16'h0004);
        rd_check("R8 summary blk", 5'h1F, 16'h0002);
    endtask

    task automatic t_error();
        ev_err = 8'h30; tick();
        check("R10 err masked", {15'h0, err_irq}, 16'h0000);
        wr(5'h14, 16'h1010);
        check("R10 err unmasked", {15'h0, err_irq}, 16'h0001);
        rd_check("R8 summary err", 5'h1F, 16'h0012);
        rd_check("R7 masked err", 5'h0C, 16'h0010);
        wr(5'h14, 16'hFF00);
        check("R10 err remasked", {15'h0, err_irq}, 16'h0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1 rst_n = 1'b1;
                t_reset();
                t_mask_write();
                t_events();
                t_raw_readonly();
                t_clear();
                t_race();
                t_error();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule